// File: doc/BRIEF.md
# Serial Peripheral Host with Register Bus

This block is a serial peripheral (SPI) host that software drives through a small word-addressed register bus. Words written to the data register go into an 8-entry transmit queue. Whenever the port is enabled, the engine takes the oldest word and shifts it out most significant bit first. At the same time it shifts in the same number of bits from the serial input. Each received frame lands in an 8-entry receive queue, and reads of the data register pop it. Chip select is not generated here. The system drives it around the transfer.

The serial clock is derived from the module clock in two stages: an even prescaler, then a rate divider of (1 + rate field). Idle level and sampling edge are programmable. A loopback switch feeds the serial output straight back to the serial input.

Four interrupt causes are provided: receive overrun, receive timeout, receive service and transmit service. Each has a raw view, a mask and a masked view, and all of them combine onto one level interrupt output.

Top module: `spi_host_regs`

## Requirements
- R1: Registers sit at byte offsets 0x00 format, 0x04 control, 0x08 data, 0x0C status, 0x10 prescaler, 0x14 mask, 0x18 raw cause, 0x1C masked cause and 0x20 cause clear. Offsets with bits 1:0 nonzero, and unlisted offsets, read 0. After reset, format reads 0x0007, control 0, prescaler 2, status 0x0003, raw 0x0008 and masked 0, and `irq` and `sclk` are low.
- R2: A data write pushes the transmit queue. A write to a full queue (8 entries) is discarded. A data read pops the receive queue in arrival order, and reading an empty queue returns 0.
- R3: Format bits 3:0 hold the frame length minus one (1 to 16 bits). Frames go out MSB first. The received word is right-aligned, and the bits above the frame length are zero.
- R4: Format bit 6 sets the idle level of `sclk`, and bit 7 selects the phase. With phase 0, `mosi` is valid before the first edge, and data is sampled on odd edges (1st, 3rd, ...). With phase 1, data is sampled on even edges. A frame has exactly 2×length edges and ends at the idle level.
- R5: Each half period of `sclk` lasts (P/2)×(1+S) module clocks. P is the prescaler value and S is format bits 15:8.
- R6: The prescaler register ignores bit 0 and bits 15:8. A value below 2 is stored as 2.
- R7: Control bit 1 enables the port. While it is clear, no frame starts and the queued words remain. Control bit 0 selects loopback.
- R8: Status bits are: 0 transmit empty, 1 transmit not full, 2 receive not empty, 3 receive full, 4 busy. Busy means a frame is shifting or the transmit queue is not empty.
- R9: Cause bits are: 0 overrun, 1 timeout, 2 receive service (receive count ≥ 4), 3 transmit service (transmit count ≤ 4). The masked view equals raw AND mask, and `irq` is high when any masked bit is set.
- R10: A frame that completes while the receive queue is full sets the overrun cause and is dropped. If a data read pops in that same cycle, the frame is stored instead and no overrun is raised.
- R11: The timeout cause sets after 32 bit periods with the receive queue non-empty and without a push or pop, counted only while the port is enabled.
- R12: Writing 1 to clear bit 0 or bit 1 clears overrun or timeout. The two service causes are not affected by the clear register.
- R13: In loopback the serial input is ignored, and the received word equals the transmitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Combined masked interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The collision that matters is a frame completing into a full receive queue in the same cycle that software pops that queue. The bench fills the receive queue with eight frames and queues one more word. It watches `sclk` until the next-to-last edge of that frame, then issues a data read that lands exactly on the finishing cycle. The bench then requires that the popped word is the oldest one, that no overrun is raised, and that the new frame appears as the ninth word when the queue is drained. A separate run without the read checks that the overrun is flagged and that the stored words are left intact.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int FIFO_DEPTH   = 8,
  parameter int ADDR_W       = 6,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int PW     = $clog2(FIFO_DEPTH);
  localparam int CW     = PW + 1;
  localparam int HALF   = FIFO_DEPTH / 2;
  localparam int TO_LIM = 2 * TIMEOUT_BITS;
  localparam int TW     = $clog2(TO_LIM + 1);

  // register bank
  logic [15:0] fmt_q;
  logic [1:0]  ctl_q;
  logic [6:0]  psc_half;
  logic [3:0]  mask_q;
  logic        ovr_raw, to_raw;

  wire              hit  = bus_req && (bus_addr[1:0] == 2'b00);
  wire [ADDR_W-3:0] widx = bus_addr[ADDR_W-1:2];
  wire wr     = hit && bus_we;
  wire rd     = hit && !bus_we;
  wire sel_dt = int'(widx) == 2;
  wire clr_wr = wr && int'(widx) == 8;

  wire [3:0] flen = fmt_q[3:0];
  wire       cpol = fmt_q[6];
  wire       cpha = fmt_q[7];
  wire [7:0] scr  = fmt_q[15:8];
  wire       loop = ctl_q[0];
  wire       en   = ctl_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fmt_q    <= 16'h0007;
      ctl_q    <= '0;
      psc_half <= 7'd1;
      mask_q   <= '0;
    end else if (wr) begin
      case (int'(widx))
        0: fmt_q    <= {bus_wdata[15:6], 2'b00, bus_wdata[3:0]};
        1: ctl_q    <= bus_wdata[1:0];
        4: psc_half <= (bus_wdata[7:1] == 7'd0) ? 7'd1 : bus_wdata[7:1];
        5: mask_q   <= bus_wdata[3:0];
        default: ;
      endcase
    end

  // transmit queue
  logic [15:0]   tx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt == CW'(FIFO_DEPTH);
  wire tx_push  = wr && sel_dt && !tx_full;
  logic tx_pop;

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  // receive queue
  logic [15:0]   rx_mem [FIFO_DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic [15:0]   rx_word;
  logic          frame_done;
  wire rx_empty = rx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(FIFO_DEPTH);
  wire rx_pop   = rd && sel_dt && !rx_empty;
  wire rx_push  = frame_done && (!rx_full || rx_pop);
  wire ovr_set  = frame_done && rx_full && !rx_pop;

  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // two-stage bit clock: even prescaler, then (1 + rate)
  logic [6:0] pre_cnt;
  logic [7:0] rate_cnt;
  logic       active;
  wire pre_wrap  = pre_cnt >= psc_half - 7'd1;
  wire half_tick = en && pre_wrap && rate_cnt >= scr;
  wire start     = en && !active && !tx_empty;
  assign tx_pop  = start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0; rate_cnt <= '0;
    end else if (start || !en) begin
      pre_cnt <= '0; rate_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      rate_cnt <= (rate_cnt >= scr) ? 8'd0 : rate_cnt + 8'd1;
    end else begin
      pre_cnt <= pre_cnt + 7'd1;
    end

  // shift engine
  logic [4:0]  kcnt;
  logic [15:0] shreg, rxsh;
  logic        mosi_r, sclk_r;
  wire [4:0]  last_k   = {flen, 1'b1};
  wire        lead     = ~kcnt[0];
  wire        step     = active && half_tick;
  wire        drive    = step && (cpha ? lead : (!lead && kcnt != last_k));
  wire        samp     = step && (cpha ? !lead : lead);
  wire        sin      = loop ? mosi_r : miso;
  wire [15:0] rx_next  = samp ? {rxsh[14:0], sin} : rxsh;
  wire [15:0] wmask    = 16'hFFFF >> (4'd15 - flen);
  wire [15:0] tx_align = tx_mem[tx_rp] << (4'd15 - flen);
  assign frame_done = step && kcnt == last_k;
  assign rx_word    = rx_next & wmask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; kcnt <= '0; shreg <= '0; rxsh <= '0;
      mosi_r <= 1'b0; sclk_r <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      kcnt   <= '0;
      rxsh   <= '0;
      sclk_r <= cpol;
      if (!cpha) begin
        mosi_r <= tx_align[15];
        shreg  <= tx_align << 1;
      end else begin
        shreg  <= tx_align;
      end
    end else if (step) begin
      sclk_r <= ~sclk_r;
      kcnt   <= kcnt + 5'd1;
      rxsh   <= rx_next;
      if (drive) begin
        mosi_r <= shreg[15];
        shreg  <= shreg << 1;
      end
      if (frame_done) active <= 1'b0;
    end else if (!active) begin
      sclk_r <= cpol;
    end

  assign sclk = sclk_r;
  assign mosi = mosi_r;

  // receive timeout
  logic [TW-1:0] to_cnt;
  wire to_hold = rx_push || rx_pop || rx_empty;
  wire to_set  = !to_hold && half_tick && to_cnt == TW'(TO_LIM - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                    to_cnt <= '0;
    else if (to_hold)                              to_cnt <= '0;
    else if (half_tick && to_cnt != TW'(TO_LIM))   to_cnt <= to_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovr_raw <= 1'b0; to_raw <= 1'b0;
    end else begin
      if (ovr_set)                      ovr_raw <= 1'b1;
      else if (clr_wr && bus_wdata[0])  ovr_raw <= 1'b0;
      if (to_set)                       to_raw  <= 1'b1;
      else if (clr_wr && bus_wdata[1])  to_raw  <= 1'b0;
    end

  wire [3:0] raw = {tx_cnt <= CW'(HALF), rx_cnt >= CW'(HALF), to_raw, ovr_raw};
  wire [3:0] mis = raw & mask_q;
  assign irq = |mis;

  wire busy = active || !tx_empty;
  wire [4:0] status = {busy, rx_full, !rx_empty, !tx_full, tx_empty};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00)
      case (int'(widx))
        0: bus_rdata = fmt_q;
        1: bus_rdata = {14'd0, ctl_q};
        2: bus_rdata = rx_empty ? 16'd0 : rx_mem[rx_rp];
        3: bus_rdata = {11'd0, status};
        4: bus_rdata = {8'd0, psc_half, 1'b0};
        5: bus_rdata = {12'd0, mask_q};
        6: bus_rdata = {12'd0, raw};
        7: bus_rdata = {12'd0, mis};
        default: bus_rdata = '0;
      endcase
  end

  AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active) && $stable(cpol)) |-> sclk == cpol); // R4
  AST_FRAME_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && $stable(cpol)) |=> sclk == $past(cpol)); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !active) |=> !active); // R7
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rx_pop) |=> ovr_raw); // R10
  AST_POP_SAVES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && rx_pop && !ovr_raw && !(clr_wr && bus_wdata[0])) |=> !ovr_raw && rx_full); // R10
  AST_CLEAR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && bus_wdata[0] && !ovr_set) |=> !ovr_raw); // R12
endmodule

// File: tb/tb_spi_host_regs.sv
`timescale 1ns/1ps
module tb_spi_host_regs;
  localparam int A_FMT = 'h00, A_CTL = 'h04, A_DAT = 'h08, A_STA = 'h0C,
                 A_PSC = 'h10, A_MSK = 'h14, A_RAW = 'h18, A_MIS = 'h1C, A_CLR = 'h20;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [5:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq, sclk, mosi, miso;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_host_regs dut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso));

  // serial monitor and slave model, sole driver of miso
  logic arm = 0, arm_seen, mon_cpha = 0;
  int mon_w = 8, edge_n = 0, slv_idx = 0;
  logic [15:0] slv_word = 0, mon_bits = 0;
  time t1 = 0, t2 = 0;
  always @(sclk or arm) begin
    if (arm !== arm_seen) begin
      arm_seen = arm; edge_n = 0; mon_bits = 0;
      if (!mon_cpha) begin miso = slv_word[mon_w-1]; slv_idx = mon_w - 2; end
      else slv_idx = mon_w - 1;
    end else begin
      #1;
      edge_n++;
      if (edge_n == 1) t1 = $time;
      if (edge_n == 2) t2 = $time;
      if ((edge_n % 2 == 1) != mon_cpha) mon_bits = {mon_bits[14:0], mosi};
      else if (slv_idx >= 0) begin miso = slv_word[slv_idx]; slv_idx--; end
    end
  end

  function automatic logic [15:0] wmask(int w);
    return 16'hFFFF >> (16 - w);
  endfunction
  function automatic int exp_half(int psc, int scr);
    int p = (psc < 2) ? 2 : (psc & 'hFE);
    return (p / 2) * (scr + 1);
  endfunction
  function automatic logic [15:0] exp_rx(logic lp, logic [15:0] tx, logic [15:0] sl, int w);
    return (lp ? tx : sl) & wmask(w);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask
  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask
  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a[5:0];
    #1 d = bus_rdata;
    @(negedge clk); bus_req = 0;
  endtask
  task automatic wait_idle();
    logic [15:0] st;
    for (int i = 0; i < 4000; i++) begin
      rd(A_STA, st);
      if (!st[4]) break;
    end
  endtask

  task automatic frame(int w, logic cpol, logic cpha, logic lp, int psc, int scr,
                       logic [15:0] txw, logic [15:0] slw);
    logic [15:0] got;
    wr(A_CTL, {15'd0, lp});
    wr(A_FMT, {scr[7:0], cpha, cpol, 2'b00, 4'(w - 1)});
    wr(A_PSC, psc[15:0]);
    repeat (3) @(negedge clk);
    mon_w = w; mon_cpha = cpha; slv_word = slw; arm = ~arm;
    wr(A_DAT, txw);
    wr(A_CTL, {14'd0, 1'b1, lp});
    wait_idle();
    rd(A_DAT, got);
    chk(lp ? "R13 loopback word" : "R3 received word", got, exp_rx(lp, txw, slw, w));
    chk("R4 edge count", 16'(edge_n), 16'(2 * w));
    chk("R4 mosi bits", mon_bits & wmask(w), txw & wmask(w));
    chk("R5 half period", 16'((t2 - t1) / 10), 16'(exp_half(psc, scr)));
    chk("R4 idle level", {15'd0, sclk}, {15'd0, cpol});
    wr(A_CTL, 16'd0);
  endtask

  logic [15:0] v;
  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset view
    rd(A_FMT, v); chk("R1 fmt reset", v, 16'h0007);
    rd(A_CTL, v); chk("R1 ctl reset", v, 16'h0000);
    rd(A_PSC, v); chk("R1 psc reset", v, 16'h0002);
    rd(A_STA, v); chk("R1 R8 status reset", v, 16'h0003);
    rd(A_RAW, v); chk("R1 R9 raw reset", v, 16'h0008);
    rd(A_MIS, v); chk("R1 masked reset", v, 16'h0000);
    rd(6'h09, v); chk("R1 unaligned reads 0", v, 16'h0000);
    chk("R1 irq/sclk reset", {14'd0, irq, sclk}, 16'h0000);
    // R6 prescaler
    wr(A_PSC, 16'h0000); rd(A_PSC, v); chk("R6 psc 0", v, 16'h0002);
    wr(A_PSC, 16'h0007); rd(A_PSC, v); chk("R6 psc odd", v, 16'h0006);
    wr(A_PSC, 16'h00FF); rd(A_PSC, v); chk("R6 psc max", v, 16'h00FE);
    wr(A_PSC, 16'h0105); rd(A_PSC, v); chk("R6 psc high bits", v, 16'h0004);
    wr(A_PSC, 16'h0001); rd(A_PSC, v); chk("R6 psc 1", v, 16'h0002);
    // R2 empty read
    rd(A_DAT, v); chk("R2 empty read", v, 16'h0000);
    // R7 disabled port keeps words
    wr(A_CTL, 16'h0001); wr(A_FMT, 16'h0007);
    for (int i = 1; i <= 9; i++) wr(A_DAT, 16'(i * 'h11));
    repeat (40) @(negedge clk);
    chk("R7 no clock while off", {15'd0, sclk}, 16'h0000);
    rd(A_STA, v); chk("R7 R8 status tx full busy", v, 16'h0010);
    rd(A_RAW, v); chk("R9 no service", v, 16'h0000);
    wr(A_CTL, 16'h0003); wait_idle();
    rd(A_STA, v); chk("R8 status rx full", v, 16'h000F);
    rd(A_RAW, v); chk("R2 R9 services, no overrun", v & 16'h000D, 16'h000C);
    repeat (100) @(negedge clk);
    rd(A_RAW, v); chk("R11 timeout set", v & 16'h0002, 16'h0002);
    wr(A_CLR, 16'h0002); rd(A_RAW, v); chk("R12 timeout cleared", v, 16'h000C);
    wr(A_CLR, 16'h000C); rd(A_RAW, v); chk("R12 services not cleared", v, 16'h000C);
    wr(A_MSK, 16'h0004); #1 chk("R9 irq on", {15'd0, irq}, 16'h0001);
    rd(A_MIS, v); chk("R9 masked", v, 16'h0004);
    wr(A_MSK, 16'h0000); #1 chk("R9 irq off", {15'd0, irq}, 16'h0000);
    // R10 pop in the completion cycle
    mon_w = 8; mon_cpha = 0; arm = ~arm;
    wr(A_DAT, 16'h00A5);
    wait (edge_n == 15);
    bus_req = 1; bus_we = 0; bus_addr = A_DAT[5:0];
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_req = 0;
    chk("R10 popped oldest", v, 16'h0011);
    repeat (5) @(negedge clk);
    rd(A_RAW, v); chk("R10 no overrun on same-cycle pop", v & 16'h0001, 16'h0000);
    for (int i = 2; i <= 8; i++) begin rd(A_DAT, v); chk("R2 R10 order", v, 16'(i * 'h11)); end
    rd(A_DAT, v); chk("R10 late frame kept", v, 16'h00A5);
    // R10 true overrun
    for (int i = 1; i <= 8; i++) wr(A_DAT, 16'(i));
    wait_idle();
    wr(A_DAT, 16'h00EE); wait_idle();
    rd(A_RAW, v); chk("R10 overrun set", v & 16'h0001, 16'h0001);
    wr(A_MSK, 16'h0001); #1 chk("R9 overrun irq", {15'd0, irq}, 16'h0001);
    wr(A_CLR, 16'h0001); rd(A_RAW, v); chk("R12 overrun cleared", v & 16'h0001, 16'h0000);
    wr(A_MSK, 16'h0000);
    for (int i = 1; i <= 8; i++) begin rd(A_DAT, v); chk("R10 stored words intact", v, 16'(i)); end
    rd(A_STA, v); chk("R8 empty after drain", v & 16'h0004, 16'h0000);
    // R11 timeout window
    wr(A_DAT, 16'h005A); wait_idle();
    repeat (30) @(negedge clk);
    rd(A_RAW, v); chk("R11 not yet timed out", v & 16'h0002, 16'h0000);
    repeat (50) @(negedge clk);
    rd(A_RAW, v); chk("R11 timed out", v & 16'h0002, 16'h0002);
    rd(A_DAT, v); wr(A_CLR, 16'h0002);
    wr(A_CTL, 16'h0000);
    // directed mode and rate corners
    frame(16, 1'b1, 1'b1, 1'b0, 6, 2, 16'hC3A5, 16'h5AF0);
    frame(1, 1'b0, 1'b0, 1'b0, 4, 0, 16'h0001, 16'h0001);
    frame(8, 1'b1, 1'b0, 1'b1, 2, 0, 16'h00B7, 16'h0048);
    // random frames
    for (int i = 0; i < 24; i++)
      frame(int'($urandom % 16) + 1, 1'($urandom), 1'($urandom), 1'(i % 2),
            (int'($urandom % 3) + 1) * 2, int'($urandom % 3),
            16'($urandom), 16'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule